// File: doc/BRIEF.md
# Double-Buffered Comparison Update Unit

This block keeps a set of compare units next to a PWM channel counter. Each unit owns an active comparison value and an active configuration, made of an enable bit and a 4-bit update period. Software never writes the active copies directly. A write through the simple register port lands in a staging copy and marks the unit as pending. The active copy is refreshed only at an update point. An update point comes on a reference-channel end-of-period pulse that also closes the unit's programmable update period.

Each unit reports two things as one-cycle registered pulses. A match pulse means the reference counter equalled the unit's active value while the unit was enabled. An update pulse means at least one staged register was copied to the active side. Because of this, a waveform generator fed by the active values sees changes only at period boundaries and never in the middle of a period.

Top module: `cmp_update_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `match_o` and `upd_o` are all zero. Reset clears every active and staging register and every pending bit, and leaves every unit disabled.
- R2: A write changes only the staging copy of the addressed unit. The active comparison value stays the same, so no match appears at the newly written value until an update point has passed.
- R3: Write encoding is as follows. `wr_kind_i`=0 selects the comparison value, which takes all of `wr_data_i`. `wr_kind_i`=1 selects the configuration, where bit 0 is the enable and bits 4:1 are the update period P.
- R4: Each unit has an update counter that moves only on `ref_eop_i`. On an end-of-period pulse the counter decrements if it is nonzero. If it is zero, that pulse is an update point and the counter reloads from P, taking the new P when the configuration is transferred at that point. Update points therefore fall on every (P+1)-th end-of-period pulse.
- R5: At an update point, the value is transferred only if a value write is pending. The configuration is transferred only if a configuration write is pending. The two transfers are independent.
- R6: `upd_o[i]` is high for exactly the one cycle after an update point at which unit i transferred at least one register.
- R7: An update point with nothing pending leaves the active registers unchanged and does not raise `upd_o[i]`.
- R8: A write in the same cycle as an update point is handled in two steps. The active side receives the previously staged data. The new data stays pending and is transferred at the next update point.
- R9: `match_o[i]` is high in the cycle after a cycle in which `ref_cnt_i` equals unit i's active value and unit i is enabled.
- R10: A disabled unit never raises `match_o[i]`, whatever the counter value.
- R11: A write to one unit changes no other unit's staging, pending or active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_cnt_i | input | VAL_W | Reference channel counter value |
| ref_eop_i | input | 1 | Reference channel end-of-period pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_unit_i | input | SEL_W | Index of the compare unit written |
| wr_kind_i | input | 1 | 0 = comparison value, 1 = configuration |
| wr_data_i | input | VAL_W | Write data |
| match_o | output | NUM_CMP | Per-unit comparison-match pulse |
| upd_o | output | NUM_CMP | Per-unit comparison-update pulse |

## Verification
Counter values are swept both to a freshly staged value and to the active one. This separates a design that writes through to the active side from one that waits for an update point. End-of-period trains are run against a nonzero update period, which tells correct (P+1) spacing apart from off-by-one counters. Value-only writes, configuration-only writes, idle update points and writes colliding with an update point each exercise a different pending-bit path. A unit that is disabled while other units stay active shows that enable gating and unit isolation are per unit.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    WR_VALUE  = 1'b0,
    WR_CONFIG = 1'b1
  } wr_kind_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_PER_LSB = 1;
endpackage

// File: rtl/cmp_upd_timer.sv
module cmp_upd_timer #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eop_i,
  input  logic [PER_W-1:0] reload_i,
  output logic             at_zero_o
);
  logic [PER_W-1:0] cnt_q;

  assign at_zero_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (eop_i) begin
      if (cnt_q == '0) cnt_q <= reload_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cmp_slot.sv
module cmp_slot #(
  parameter int VAL_W = 16,
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eop_i,
  input  logic             wr_val_i,
  input  logic             wr_cfg_i,
  input  logic [VAL_W-1:0] wr_data_i,
  output logic [VAL_W-1:0] act_val_o,
  output logic             act_en_o,
  output logic             pend_o,
  output logic             xfer_o
);
  import cmp_pkg::*;

  logic [VAL_W-1:0] stg_val_q, act_val_q;
  logic             stg_en_q, act_en_q;
  logic [PER_W-1:0] stg_per_q, act_per_q;
  logic             val_pend_q, cfg_pend_q;
  logic             at_zero, upd_pt, xfer_val, xfer_cfg;
  logic [PER_W-1:0] reload_per;

  assign upd_pt     = eop_i & at_zero;
  assign xfer_val   = upd_pt & val_pend_q;
  assign xfer_cfg   = upd_pt & cfg_pend_q;
  assign reload_per = xfer_cfg ? stg_per_q : act_per_q;

  cmp_upd_timer #(.PER_W(PER_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .eop_i     (eop_i),
    .reload_i  (reload_per),
    .at_zero_o (at_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_val_q  <= '0;
      stg_en_q   <= 1'b0;
      stg_per_q  <= '0;
      val_pend_q <= 1'b0;
      cfg_pend_q <= 1'b0;
      act_val_q  <= '0;
      act_en_q   <= 1'b0;
      act_per_q  <= '0;
    end else begin
      if (wr_val_i) stg_val_q <= wr_data_i;
      if (wr_cfg_i) begin
        stg_en_q  <= wr_data_i[CFG_EN_BIT];
        stg_per_q <= wr_data_i[CFG_PER_LSB +: PER_W];
      end
      val_pend_q <= (val_pend_q & ~xfer_val) | wr_val_i;
      cfg_pend_q <= (cfg_pend_q & ~xfer_cfg) | wr_cfg_i;
      if (xfer_val) act_val_q <= stg_val_q;
      if (xfer_cfg) begin
        act_en_q  <= stg_en_q;
        act_per_q <= stg_per_q;
      end
    end
  end

  assign act_val_o = act_val_q;
  assign act_en_o  = act_en_q;
  assign pend_o    = val_pend_q | cfg_pend_q;
  assign xfer_o    = xfer_val | xfer_cfg;
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] cnt_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             en_i,
  output logic             match_o
);
  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= en_i & (cnt_i == val_i);
  end

  assign match_o = hit_q;
endmodule

// File: rtl/cmp_update_unit.sv
module cmp_update_unit #(
  parameter int NUM_CMP = 8,
  parameter int VAL_W   = 16,
  parameter int PER_W   = 4,
  localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VAL_W-1:0]   ref_cnt_i,
  input  logic               ref_eop_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_unit_i,
  input  logic               wr_kind_i,
  input  logic [VAL_W-1:0]   wr_data_i,
  output logic [NUM_CMP-1:0] match_o,
  output logic [NUM_CMP-1:0] upd_o
);
  import cmp_pkg::*;

  logic [NUM_CMP-1:0]       pend_any;
  logic [NUM_CMP-1:0]       act_en_vec;
  logic [NUM_CMP-1:0]       xfer_vec;
  logic [NUM_CMP*VAL_W-1:0] act_val_flat;
  logic [NUM_CMP-1:0]       upd_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_unit
    logic sel, wr_val, wr_cfg;
    logic [VAL_W-1:0] act_val;

    assign sel    = wr_en_i && (int'(wr_unit_i) == g);
    assign wr_val = sel && (wr_kind_e'(wr_kind_i) == WR_VALUE);
    assign wr_cfg = sel && (wr_kind_e'(wr_kind_i) == WR_CONFIG);

    cmp_slot #(.VAL_W(VAL_W), .PER_W(PER_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .eop_i     (ref_eop_i),
      .wr_val_i  (wr_val),
      .wr_cfg_i  (wr_cfg),
      .wr_data_i (wr_data_i),
      .act_val_o (act_val),
      .act_en_o  (act_en_vec[g]),
      .pend_o    (pend_any[g]),
      .xfer_o    (xfer_vec[g])
    );

    cmp_match_unit #(.VAL_W(VAL_W)) u_match (
      .clk     (clk),
      .rst     (rst),
      .cnt_i   (ref_cnt_i),
      .val_i   (act_val),
      .en_i    (act_en_vec[g]),
      .match_o (match_o[g])
    );

    assign act_val_flat[g*VAL_W +: VAL_W] = act_val;
  end

  always_ff @(posedge clk) begin
    if (rst) upd_q <= '0;
    else     upd_q <= xfer_vec;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/cmp_update_unit_chk.sv
module cmp_update_unit_chk #(
  parameter int NUM_CMP = 8,
  parameter int VAL_W   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     eop_i,
  input logic [NUM_CMP-1:0]       upd_o,
  input logic [NUM_CMP-1:0]       match_o,
  input logic [NUM_CMP-1:0]       pend_any,
  input logic [NUM_CMP-1:0]       act_en,
  input logic [NUM_CMP*VAL_W-1:0] act_val_flat
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (upd_o == '0 && match_o == '0));

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eop_i |=> $stable(act_val_flat) && $stable(act_en));

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_chk
    // R6
    upd_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
      upd_o[g] |-> $past(eop_i));

    // R7
    upd_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
      upd_o[g] |-> $past(pend_any[g]));

    // R10
    match_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      match_o[g] |-> $past(act_en[g]));
  end
endmodule

bind cmp_update_unit cmp_update_unit_chk #(.NUM_CMP(NUM_CMP), .VAL_W(VAL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .eop_i        (ref_eop_i),
  .upd_o        (upd_o),
  .match_o      (match_o),
  .pend_any     (pend_any),
  .act_en       (act_en_vec),
  .act_val_flat (act_val_flat)
);

// File: tb/cmp_update_unit_test.sv
module cmp_update_unit_test;
  localparam int NUM_CMP = 8;
  localparam int VAL_W   = 16;
  localparam int SEL_W   = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [VAL_W-1:0]   ref_cnt_i = '0;
  logic               ref_eop_i = 1'b0;
  logic               wr_en_i = 1'b0;
  logic [SEL_W-1:0]   wr_unit_i = '0;
  logic               wr_kind_i = 1'b0;
  logic [VAL_W-1:0]   wr_data_i = '0;
  logic [NUM_CMP-1:0] match_o, upd_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cmp_update_unit #(.NUM_CMP(NUM_CMP), .VAL_W(VAL_W), .PER_W(4)) uut (
    .clk(clk), .rst(rst), .ref_cnt_i(ref_cnt_i), .ref_eop_i(ref_eop_i),
    .wr_en_i(wr_en_i), .wr_unit_i(wr_unit_i), .wr_kind_i(wr_kind_i),
    .wr_data_i(wr_data_i), .match_o(match_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one write for one cycle (R3 encoding)
  task automatic wr(input int unit, input bit kind, input int data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_unit_i = SEL_W'(unit); wr_kind_i = kind; wr_data_i = VAL_W'(data);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // one end-of-period pulse; returns upd_o seen the cycle after
  task automatic eop(output logic [NUM_CMP-1:0] u);
    @(negedge clk);
    ref_eop_i = 1'b1;
    @(negedge clk);
    ref_eop_i = 1'b0;
    u = upd_o;
  endtask

  // present a counter value and return the match bit of a unit
  task automatic probe(input int unit, input int cnt, output logic m);
    @(negedge clk);
    ref_cnt_i = VAL_W'(cnt);
    @(negedge clk);
    m = match_o[unit];
    ref_cnt_i = 16'hFFFF;
  endtask

  function automatic int cfg(input bit en, input int per);
    return (per << 1) | int'(en);
  endfunction

  task automatic t_reset();
    logic m;
    chk("R1 upd", 32'(upd_o), 0);
    chk("R1 match", 32'(match_o), 0);
    probe(0, 0, m);
    chk("R10 disabled after reset", 32'(m), 0);
  endtask

  task automatic t_stage_only();
    logic m;
    wr(0, 1'b0, 100);
    wr(0, 1'b1, cfg(1'b1, 0));
    probe(0, 100, m);
    chk("R2 staged value inactive", 32'(m), 0);
  endtask

  task automatic t_first_update();
    logic [NUM_CMP-1:0] u;
    logic m;
    eop(u);
    chk("R6 R11 update only unit0", 32'(u), 32'h01);
    probe(0, 100, m);
    chk("R9 match at active value", 32'(m), 1);
    probe(0, 99, m);
    chk("R9 no match off value", 32'(m), 0);
  endtask

  task automatic t_idle_update();
    logic [NUM_CMP-1:0] u;
    logic m;
    eop(u);
    chk("R7 no pending no update", 32'(u), 0);
    probe(0, 100, m);
    chk("R7 active kept", 32'(m), 1);
  endtask

  task automatic t_value_only();
    logic [NUM_CMP-1:0] u;
    logic m;
    wr(0, 1'b0, 200);
    eop(u);
    chk("R5 value-only update", 32'(u[0]), 1);
    probe(0, 200, m);
    chk("R5 enable kept, new value", 32'(m), 1);
  endtask

  task automatic t_period();
    logic [NUM_CMP-1:0] u;
    logic m;
    wr(1, 1'b1, cfg(1'b1, 2));
    eop(u);
    chk("R4 cfg transfer at zero", 32'(u[1]), 1);
    wr(1, 1'b0, 50);
    for (int k = 0; k < 2; k++) begin
      eop(u);
      chk("R4 mid-period no update", 32'(u[1]), 0);
    end
    probe(1, 50, m);
    chk("R4 value not yet active", 32'(m), 0);
    eop(u);
    chk("R4 update on third pulse", 32'(u[1]), 1);
    probe(1, 50, m);
    chk("R4 value active", 32'(m), 1);
  endtask

  task automatic t_collision();
    logic [NUM_CMP-1:0] u;
    logic m;
    wr(2, 1'b0, 10);
    wr(2, 1'b1, cfg(1'b1, 0));
    eop(u);
    wr(2, 1'b0, 30);
    @(negedge clk);
    ref_eop_i = 1'b1; wr_en_i = 1'b1; wr_unit_i = 3'd2; wr_kind_i = 1'b0; wr_data_i = 16'd40;
    @(negedge clk);
    ref_eop_i = 1'b0; wr_en_i = 1'b0;
    chk("R8 collision update", 32'(upd_o[2]), 1);
    probe(2, 30, m);
    chk("R8 older staged applied", 32'(m), 1);
    eop(u);
    chk("R8 kept pending", 32'(u[2]), 1);
    probe(2, 40, m);
    chk("R8 newer applied next", 32'(m), 1);
  endtask

  task automatic t_disable();
    logic [NUM_CMP-1:0] u;
    logic m;
    wr(0, 1'b1, cfg(1'b0, 0));
    eop(u);
    probe(0, 200, m);
    chk("R10 disabled unit silent", 32'(m), 0);
    probe(2, 40, m);
    chk("R11 other unit unaffected", 32'(m), 1);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ref_cnt_i = 16'hFFFF;
    @(negedge clk);
    t_reset();
    t_stage_only();
    t_first_update();
    t_idle_update();
    t_value_only();
    t_period();
    t_collision();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule